// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small set of ownership tokens that two independent ports share in order to reserve common resources. Each port can request a token, release it, or read back whether it currently holds it. A token is free, held by the left port, or held by the right port. A port that asks for a token the other side already holds is not refused. Its request is remembered, and the token passes to it in the same clock edge that accepts the holder's release.

Every access is synchronous to one clock. A port takes part in a cycle when its semaphore select is low while its array enable is high. The low bits of the address pick the token. Only data bit 0 matters on a write. A read loads a per-port output register with the ownership bit copied onto every data bit. That register changes only on a read, so a write from the other side in the same cycle cannot disturb the value being returned.

Top module: `dpsem_bank`

## Requirements
- R1: Synchronous reset (rst high) frees all eight tokens and clears every pending request. After reset both read registers hold 8'hFF.
- R2: The token index is address bits [2:0]. Address bits above bit 2 have no effect on any access.
- R3: A port takes part in a cycle only when sem_n=0 and ram_en_n=1. With both low, or with sem_n high, the access is ignored. The read register of a port changes only on one of its own valid reads.
- R4: A valid write (wr_n=0) uses only wdata[0]. A 0 requests the token and a 1 releases it or cancels a pending request. Bits [7:1] are ignored.
- R5: When a port requests a free token, that port reads 8'h00 from it and the other port reads 8'hFF.
- R6: A request for a token held by the other side leaves both read values unchanged and is recorded as pending.
- R7: When the holder releases a token for which the other side has a pending request, that other side becomes holder on the same clock edge. A request arriving in the same cycle as the release also counts.
- R8: A release with no pending request leaves the token free, and both ports then read 8'hFF.
- R9: A valid read (wr_n=1) loads the port's read register one clock later with 8'h00 if the port held the token before that edge, else 8'hFF. The value reflects the state before any write made in the same cycle.
- R10: If both ports request the same free token in the same cycle, the left port gets it and the right request stays pending.
- R11: A holder writing 0 again changes nothing. A port that neither holds nor awaits a token and writes 1 changes nothing. A waiting port that writes 1 withdraws its request, so a later release frees the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_sem_n | input | 1 | Left semaphore select, active low |
| lt_ram_en_n | input | 1 | Left array enable, active low; must be high for a token access |
| lt_wr_n | input | 1 | Left write strobe, active low (high = read) |
| lt_addr | input | ADDR_W | Left address; bits [2:0] pick the token |
| lt_wdata | input | DATA_W | Left write data; bit 0 used |
| lt_rdata | output | DATA_W | Left read register |
| rt_sem_n | input | 1 | Right semaphore select, active low |
| rt_ram_en_n | input | 1 | Right array enable, active low; must be high for a token access |
| rt_wr_n | input | 1 | Right write strobe, active low (high = read) |
| rt_addr | input | ADDR_W | Right address; bits [2:0] pick the token |
| rt_wdata | input | DATA_W | Right write data; bit 0 used |
| rt_rdata | output | DATA_W | Right read register |

## Verification
The bench targets these corner cases:
- Both ports requesting one free token in the same cycle. A wrong tie-break gives the token to the right side, or to both, or to neither.
- A release that lands in the same cycle as the waiting side's request. A design that ignores a same-cycle request frees the token instead of handing it over.
- A read issued while the other port writes the same token. A design that reads post-update state returns the new ownership instead of the old one.
- Writes made with both enables low, writes with dirty upper address and data bits, and a waiting request that is withdrawn before release. A flawed decoder or pending latch shows up as a wrong owner on a later read.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_own_e;

    typedef struct packed {
        tok_own_e own;
        logic     wait_l;
        logic     wait_r;
    } tok_cell_s;

endpackage

// File: rtl/dpsem_port_dec.sv
module dpsem_port_dec #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic               sem_n,
    input  logic               ram_en_n,
    input  logic               wr_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               rd_hit,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SEM-1:0] req_hot,
    output logic [NUM_SEM-1:0] rel_hot
);

    logic valid_acc;
    logic wr_acc;
    logic unused_bits;

    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    always_comb begin
        valid_acc = !sem_n && ram_en_n;
        wr_acc    = valid_acc && !wr_n;
        rd_hit    = valid_acc && wr_n;
        idx       = addr[IDX_W-1:0];
    end

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_hot
        always_comb begin
            req_hot[k] = wr_acc && (idx == IDX_W'(k)) && !wdata[0];
            rel_hot[k] = wr_acc && (idx == IDX_W'(k)) &&  wdata[0];
        end
    end

endmodule

// File: rtl/dpsem_cell.sv
module dpsem_cell
    import dpsem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r
);

    tok_cell_s cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        unique case (cell_q.own)
            TOK_FREE: begin
                cell_d.wait_l = 1'b0;
                cell_d.wait_r = 1'b0;
                if (l_req) begin
                    cell_d.own    = TOK_LEFT;
                    cell_d.wait_r = r_req;
                end else if (r_req) begin
                    cell_d.own = TOK_RIGHT;
                end
            end
            TOK_LEFT: begin
                cell_d.wait_l = 1'b0;
                if (r_req) cell_d.wait_r = 1'b1;
                if (r_rel) cell_d.wait_r = 1'b0;
                if (l_rel) begin
                    if (cell_d.wait_r) begin
                        cell_d.own    = TOK_RIGHT;
                        cell_d.wait_r = 1'b0;
                    end else begin
                        cell_d.own = TOK_FREE;
                    end
                end
            end
            TOK_RIGHT: begin
                cell_d.wait_r = 1'b0;
                if (l_req) cell_d.wait_l = 1'b1;
                if (l_rel) cell_d.wait_l = 1'b0;
                if (r_rel) begin
                    if (cell_d.wait_l) begin
                        cell_d.own    = TOK_LEFT;
                        cell_d.wait_l = 1'b0;
                    end else begin
                        cell_d.own = TOK_FREE;
                    end
                end
            end
            default: begin
                cell_d.own    = TOK_FREE;
                cell_d.wait_l = 1'b0;
                cell_d.wait_r = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q.own    <= TOK_FREE;
            cell_q.wait_l <= 1'b0;
            cell_q.wait_r <= 1'b0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign own_l = (cell_q.own == TOK_LEFT);
    assign own_r = (cell_q.own == TOK_RIGHT);

endmodule

// File: rtl/dpsem_rdreg.sv
module dpsem_rdreg #(
    parameter int DATA_W  = 8,
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_hit,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_hit) rdata_d = {DATA_W{~own_vec[idx]}};
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= {DATA_W{1'b1}};
        else     rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dpsem_bank.sv
module dpsem_bank #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_sem_n,
    input  logic              lt_ram_en_n,
    input  logic              lt_wr_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    input  logic              rt_sem_n,
    input  logic              rt_ram_en_n,
    input  logic              rt_wr_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata
);

    logic               l_rd, r_rd;
    logic [IDX_W-1:0]   l_idx, r_idx;
    logic [NUM_SEM-1:0] l_req_hot, l_rel_hot, r_req_hot, r_rel_hot;
    logic [NUM_SEM-1:0] cell_own_l, cell_own_r;

    dpsem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
        .sem_n(lt_sem_n), .ram_en_n(lt_ram_en_n), .wr_n(lt_wr_n),
        .addr(lt_addr), .wdata(lt_wdata), .rd_hit(l_rd), .idx(l_idx),
        .req_hot(l_req_hot), .rel_hot(l_rel_hot)
    );

    dpsem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
        .sem_n(rt_sem_n), .ram_en_n(rt_ram_en_n), .wr_n(rt_wr_n),
        .addr(rt_addr), .wdata(rt_wdata), .rd_hit(r_rd), .idx(r_idx),
        .req_hot(r_req_hot), .rel_hot(r_rel_hot)
    );

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_tok
        dpsem_cell u_cell (
            .clk(clk), .rst(rst),
            .l_req(l_req_hot[k]), .l_rel(l_rel_hot[k]),
            .r_req(r_req_hot[k]), .r_rel(r_rel_hot[k]),
            .own_l(cell_own_l[k]), .own_r(cell_own_r[k])
        );
    end

    dpsem_rdreg #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rd_l (
        .clk(clk), .rst(rst), .rd_hit(l_rd), .idx(l_idx),
        .own_vec(cell_own_l), .rdata(lt_rdata)
    );

    dpsem_rdreg #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rd_r (
        .clk(clk), .rst(rst), .rd_hit(r_rd), .idx(r_idx),
        .own_vec(cell_own_r), .rdata(rt_rdata)
    );

endmodule

// File: rtl/dpsem_bank_chk.sv
module dpsem_bank_chk #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst,
    input logic               lt_sem_n,
    input logic               lt_ram_en_n,
    input logic               lt_wr_n,
    input logic [ADDR_W-1:0]  lt_addr,
    input logic [DATA_W-1:0]  lt_wdata,
    input logic [DATA_W-1:0]  lt_rdata,
    input logic               rt_sem_n,
    input logic               rt_ram_en_n,
    input logic               rt_wr_n,
    input logic [ADDR_W-1:0]  rt_addr,
    input logic [DATA_W-1:0]  rt_wdata,
    input logic [DATA_W-1:0]  rt_rdata,
    input logic [NUM_SEM-1:0] cell_own_l,
    input logic [NUM_SEM-1:0] cell_own_r
);

    logic             c_lrd, c_rrd, c_lreq, c_rreq, c_lwr;
    logic [IDX_W-1:0] c_lidx, c_ridx;
    logic [NUM_SEM-1:0] c_lrel_hot;

    assign c_lrd  = !lt_sem_n && lt_ram_en_n && lt_wr_n;
    assign c_rrd  = !rt_sem_n && rt_ram_en_n && rt_wr_n;
    assign c_lwr  = !lt_sem_n && lt_ram_en_n && !lt_wr_n;
    assign c_lreq = c_lwr && !lt_wdata[0];
    assign c_rreq = !rt_sem_n && rt_ram_en_n && !rt_wr_n && !rt_wdata[0];
    assign c_lidx = lt_addr[IDX_W-1:0];
    assign c_ridx = rt_addr[IDX_W-1:0];

    always_comb begin
        c_lrel_hot = '0;
        if (c_lwr && lt_wdata[0]) c_lrel_hot[c_lidx] = 1'b1;
    end

    // R1: reset leaves both read registers showing free
    a_r1_reset_free: assert property (@(posedge clk)
        rst |=> (lt_rdata == {DATA_W{1'b1}} && rt_rdata == {DATA_W{1'b1}}));

    // R3: read register holds without a valid read
    a_r3_left_hold: assert property (@(posedge clk) disable iff (rst)
        !c_lrd |=> $stable(lt_rdata));
    a_r3_right_hold: assert property (@(posedge clk) disable iff (rst)
        !c_rrd |=> $stable(rt_rdata));

    // R9: read value copied onto every bit and taken from pre-edge ownership
    a_r9_left_reflect: assert property (@(posedge clk) disable iff (rst)
        c_lrd |=> lt_rdata == {DATA_W{~$past(cell_own_l[c_lidx])}});
    a_r9_right_reflect: assert property (@(posedge clk) disable iff (rst)
        c_rrd |=> rt_rdata == {DATA_W{~$past(cell_own_r[c_ridx])}});

    // R6: left ownership is lost only through a left release
    a_r6_left_keeps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(cell_own_l) & ~$past(c_lrel_hot)) & ~cell_own_l) == '0));

    // R10: simultaneous requests for a free token go to the left port
    a_r10_left_wins: assert property (@(posedge clk) disable iff (rst)
        (c_lreq && c_rreq && c_lidx == c_ridx && !cell_own_l[c_lidx] && !cell_own_r[c_lidx])
        |=> (cell_own_l[$past(c_lidx)] && !cell_own_r[$past(c_lidx)]));

endmodule

bind dpsem_bank dpsem_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_chk (.*);

// File: tb/dpsem_bank_test.sv
module dpsem_bank_test;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int NSEM   = 8;

    // op codes: 0 idle, 1 read, 2 write, 3 write with both enables low,
    // 4 read with both enables low, 5 array-only write (sem_n high)
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lt_sem_n = 1'b1, lt_ram_en_n = 1'b1, lt_wr_n = 1'b1;
    logic [ADDR_W-1:0] lt_addr = '0;
    logic [DATA_W-1:0] lt_wdata = '0;
    logic [DATA_W-1:0] lt_rdata;
    logic              rt_sem_n = 1'b1, rt_ram_en_n = 1'b1, rt_wr_n = 1'b1;
    logic [ADDR_W-1:0] rt_addr = '0;
    logic [DATA_W-1:0] rt_wdata = '0;
    logic [DATA_W-1:0] rt_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int own_m [NSEM];
    bit pend_l [NSEM];
    bit pend_r [NSEM];
    logic [DATA_W-1:0] exp_l = 8'hFF, exp_r = 8'hFF;
    logic [31:0] seed = 32'h1357_9BDF;

    always #10 clk = ~clk;

    dpsem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NSEM)) uut (.*);

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check8(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update(input int lop, input int li, input int lb,
                                input int rop, input int ri, input int rb);
        for (int k = 0; k < NSEM; k++) begin
            bit lq, lr, rq, rr;
            lq = (lop == 2) && (li == k) && (lb == 0);
            lr = (lop == 2) && (li == k) && (lb == 1);
            rq = (rop == 2) && (ri == k) && (rb == 0);
            rr = (rop == 2) && (ri == k) && (rb == 1);
            case (own_m[k])
                0: begin
                    if (lq) begin own_m[k] = 1; pend_r[k] = rq; end
                    else if (rq) own_m[k] = 2;
                end
                1: begin
                    if (rq) pend_r[k] = 1;
                    if (rr) pend_r[k] = 0;
                    if (lr) begin
                        if (pend_r[k]) begin own_m[k] = 2; pend_r[k] = 0; end
                        else own_m[k] = 0;
                    end
                end
                default: begin
                    if (lq) pend_l[k] = 1;
                    if (lr) pend_l[k] = 0;
                    if (rr) begin
                        if (pend_l[k]) begin own_m[k] = 1; pend_l[k] = 0; end
                        else own_m[k] = 0;
                    end
                end
            endcase
        end
    endtask

    // one clock cycle with both ports; called and returns at a negedge
    task automatic cyc(input int lop, input int li, input int lb,
                       input int rop, input int ri, input int rb, input string tag);
        logic [31:0] r;
        r = rnd();
        lt_sem_n    = !(lop >= 1 && lop <= 4);
        lt_ram_en_n = !(lop >= 3);
        lt_wr_n     = !(lop == 2 || lop == 3 || lop == 5);
        lt_addr     = {r[ADDR_W-1:3], 3'(li)};
        lt_wdata    = {r[20:14], 1'(lb)};
        rt_sem_n    = !(rop >= 1 && rop <= 4);
        rt_ram_en_n = !(rop >= 3);
        rt_wr_n     = !(rop == 2 || rop == 3 || rop == 5);
        rt_addr     = {r[31:22], 3'(ri)};
        rt_wdata    = {r[27:21], 1'(rb)};
        if (lop == 1) exp_l = {DATA_W{own_m[li] != 1}};
        if (rop == 1) exp_r = {DATA_W{own_m[ri] != 2}};
        model_update(lop, li, lb, rop, ri, rb);
        @(posedge clk);
        @(negedge clk);
        lt_sem_n = 1'b1; rt_sem_n = 1'b1;
        lt_ram_en_n = 1'b1; rt_ram_en_n = 1'b1;
        lt_wr_n = 1'b1; rt_wr_n = 1'b1;
        check8({tag, " left"},  lt_rdata, exp_l);
        check8({tag, " right"}, rt_rdata, exp_r);
    endtask

    task automatic read_both(input int k, input string tag);
        cyc(1, k, 0, 1, k, 0, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int k = 0; k < NSEM; k++) begin own_m[k] = 0; pend_l[k] = 0; pend_r[k] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check8("R1 reset left",  lt_rdata, 8'hFF);
        check8("R1 reset right", rt_rdata, 8'hFF);
        for (int k = 0; k < NSEM; k++) read_both(k, "R1 all free");

        // R5, R2, R4: left requests token 3 with dirty upper bits
        cyc(2, 3, 0, 0, 0, 0, "R5 request");
        read_both(3, "R5 owner view");
        // R6: right request while left holds
        cyc(0, 0, 0, 2, 3, 0, "R6 request held");
        read_both(3, "R6 unchanged");
        // R7: release hands over to waiting right
        cyc(2, 3, 1, 0, 0, 0, "R7 release");
        read_both(3, "R7 handover");
        // R8: right releases, nothing pending
        cyc(0, 0, 0, 2, 3, 1, "R8 release");
        read_both(3, "R8 free");
        // R10: simultaneous requests, left wins, right pending
        cyc(2, 5, 0, 2, 5, 0, "R10 tie");
        read_both(5, "R10 left wins");
        cyc(2, 5, 1, 0, 0, 0, "R10 release");
        read_both(5, "R10 right granted");
        // R11: left waits then withdraws; right owner rewrites 0
        cyc(2, 5, 0, 2, 5, 0, "R11 rerequest");
        cyc(2, 5, 1, 0, 0, 0, "R11 withdraw");
        read_both(5, "R11 still right");
        cyc(0, 0, 0, 2, 5, 1, "R11 release");
        read_both(5, "R11 freed");
        cyc(0, 0, 0, 2, 6, 1, "R11 stray release");
        read_both(6, "R11 no change");
        // R7: release and request land in the same cycle
        cyc(2, 2, 0, 0, 0, 0, "R7 take");
        cyc(2, 2, 1, 2, 2, 0, "R7 same cycle");
        read_both(2, "R7 same-cycle handover");
        // R3: illegal and array-only writes ignored
        cyc(3, 0, 0, 5, 0, 0, "R3 illegal write");
        read_both(0, "R3 ignored");
        cyc(4, 2, 0, 4, 2, 0, "R3 illegal read hold");
        // R9: read concurrent with other-port request
        cyc(1, 1, 0, 2, 1, 0, "R9 read during write");
        read_both(1, "R9 after write");

        // near-exhaustive random mix over all tokens and ops
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r;
            int lop, rop, li, ri;
            r   = rnd();
            lop = int'(r[2:0]) % 6;
            rop = int'(r[5:3]) % 6;
            li  = int'(r[8:6]);
            ri  = r[9] ? li : int'(r[12:10]);
            cyc(lop, li, int'(r[13]), rop, ri, int'(r[14]), "R2 R4 R9 sweep");
        end
        for (int k = 0; k < NSEM; k++) read_both(k, "R9 final");
        summary();
    end

endmodule